// File: doc/BRIEF.md
# Power-On Configuration Strap Capture and Control Decode

This block sits beside the clock outputs of a system clock generator. After power-on reset, six shared pins spend a fixed window as configuration inputs. The block resynchronises their levels and keeps updating a strap register until the window closes. Then it freezes that register and enables the output drivers on the same pins. The window is a count of reference-clock cycles after the power-on reset input is released.

From the frozen straps and a few configuration-register bits, it derives the live operating controls:
- the three-bit frequency code, taken from the straps or from the register;
- whether the SDRAM clocks follow the CPU rate or the AGP rate;
- the CPU buffer-voltage indication;
- the role of a pair of mode-dependent pins. In mobile mode they are active-low stop inputs, resynchronised into CPU and PCI halt requests. In desktop mode they are two extra SDRAM clock outputs, each gated by its register enable.

Top module: `strap_cfg_latch`

## Requirements
- R1: While `por_n` is low, `por_done` and all output enables are 0. `por_done` rises on exactly the `POR_CYCLES`-th rising clock edge after `por_n` goes high and then stays 1 until the next power-on reset. `strap_pad_oe` is all ones exactly when `por_done` is 1.
- R2: Once `por_done` is 1, level changes on `strap_pad_in` have no effect on any decoded output.
- R3: The captured strap value is the `strap_pad_in` level sampled at the rising edge two edges before the edge that sets `por_done`. A change made after that edge is not captured. With the default `POR_CYCLES` of 8, that is edge 6 of 8.
- R4: `sdram_track_cpu` equals the captured strap bit 3: 1 means SDRAM at the CPU rate, 0 means at the AGP rate.
- R5: Captured strap bit 4 is the mode: 1 is desktop, 0 is mobile.
  - `desktop_mode` shows it.
  - After `por_done`, `pair_pad_oe` is 2'b11 in desktop mode and 2'b00 in mobile mode.
  - In desktop mode, levels on `stop_pad_in` never raise a halt request.
- R6: The frequency code comes from `cfg_freq_code` when `cfg_freq_sel` is 1. When it is 0, the code comes from captured strap bits 2:0. The selection follows `cfg_freq_sel` with no clock delay.
- R7: `cpu_buf_low_v` equals captured strap bit 5: 1 selects 2.5 V CPU buffers, 0 selects 3.3 V buffers.
- R8: `pair_clk_en[i]` is 1 only when `cfg_pair_en[i]` is 1, the mode is desktop and `por_done` is 1. Otherwise it is 0.
- R9: In mobile mode after `por_done`, the halt requests follow the active-low stop pins through two flops:
  - `cpu_halt_req` follows `stop_pad_in[0]` inverted;
  - `pci_halt_req` follows `stop_pad_in[1]` inverted;
  - a level seen at one rising edge shows on the request after the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| strap_pad_in | input | 6 | Shared pin levels: [2:0] frequency, [3] SDRAM rate source, [4] mode, [5] CPU buffer voltage |
| stop_pad_in | input | 2 | Mode-dependent pin levels: [0] CPU stop, [1] PCI stop (active low in mobile mode) |
| cfg_freq_sel | input | 1 | Register bit: 1 takes the frequency code from the register |
| cfg_freq_code | input | 3 | Register frequency code |
| cfg_pair_en | input | 2 | Register enables for the two extra SDRAM clocks, [0] on stop pin 0, [1] on stop pin 1 |
| strap_pad_oe | output | 6 | Output enables of the shared pins |
| pair_pad_oe | output | 2 | Output enables of the mode-dependent pins |
| por_done | output | 1 | Strap window closed |
| freq_code | output | 3 | Selected frequency code |
| sdram_track_cpu | output | 1 | 1: SDRAM at CPU rate, 0: at AGP rate |
| desktop_mode | output | 1 | Captured mode |
| cpu_buf_low_v | output | 1 | 1: 2.5 V CPU buffers |
| pair_clk_en | output | 2 | Effective run enables of the two extra SDRAM clocks |
| cpu_halt_req | output | 1 | CPU clock stop request |
| pci_halt_req | output | 1 | PCI clock stop request |

## Verification
The assertions assume the following:
- `POR_CYCLES` is at least 3, so the strap resynchroniser fills before the register freezes.
- The stop pins only matter once the window has closed.
- The register inputs may change at any time.

The stimulus meets these conditions:
- It keeps the strap levels steady across each capture window, except in the test aimed at the sampling edge.
- It holds the stop pins high (inactive) through reset.
- It changes every input just after a rising edge, so each change sits clear of the sampling edge.

// File: rtl/strap_cfg_latch.sv
module strap_cfg_latch #(
  parameter int POR_CYCLES = 8
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic [5:0] strap_pad_in,
  input  logic [1:0] stop_pad_in,
  input  logic       cfg_freq_sel,
  input  logic [2:0] cfg_freq_code,
  input  logic [1:0] cfg_pair_en,
  output logic [5:0] strap_pad_oe,
  output logic [1:0] pair_pad_oe,
  output logic       por_done,
  output logic [2:0] freq_code,
  output logic       sdram_track_cpu,
  output logic       desktop_mode,
  output logic       cpu_buf_low_v,
  output logic [1:0] pair_clk_en,
  output logic       cpu_halt_req,
  output logic       pci_halt_req
);
  localparam int CNT_W = $clog2(POR_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(POR_CYCLES - 1);

  logic [CNT_W-1:0] win_cnt;
  logic [5:0] strap_s1, strap_s2, strap_q;
  logic [1:0] stop_s1, stop_s2;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      win_cnt  <= '0;
      por_done <= 1'b0;
    end else if (!por_done) begin
      win_cnt <= win_cnt + 1'b1;
      if (win_cnt == LAST) por_done <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      strap_s1 <= '0;
      strap_s2 <= '0;
      strap_q  <= '0;
    end else if (!por_done) begin
      strap_s1 <= strap_pad_in;
      strap_s2 <= strap_s1;
      strap_q  <= strap_s2;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      stop_s1 <= 2'b11;
      stop_s2 <= 2'b11;
    end else begin
      stop_s1 <= stop_pad_in;
      stop_s2 <= stop_s1;
    end
  end

  assign desktop_mode    = strap_q[4];
  assign sdram_track_cpu = strap_q[3];
  assign cpu_buf_low_v   = strap_q[5];
  assign freq_code       = cfg_freq_sel ? cfg_freq_code : strap_q[2:0];
  assign strap_pad_oe    = {6{por_done}};
  assign pair_pad_oe     = {2{por_done & desktop_mode}};
  assign pair_clk_en     = cfg_pair_en & pair_pad_oe;
  assign cpu_halt_req    = por_done & ~desktop_mode & ~stop_s2[0];
  assign pci_halt_req    = por_done & ~desktop_mode & ~stop_s2[1];

  // R1
  done_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
    por_done |=> por_done);

  // R2
  strap_frozen_chk: assert property (@(posedge clk) disable iff (!por_n)
    (por_done && $past(por_done)) |-> $stable(strap_q));

  // R5
  desk_no_halt_chk: assert property (@(posedge clk) disable iff (!por_n)
    desktop_mode |-> (!cpu_halt_req && !pci_halt_req));

  // R8
  pair_gate_chk: assert property (@(posedge clk) disable iff (!por_n)
    (pair_clk_en != 2'b00) |-> (desktop_mode && por_done));

  // R9
  cpu_halt_sync_chk: assert property (@(posedge clk) disable iff (!por_n)
    cpu_halt_req |-> !$past(stop_pad_in[0], 2));

  // R9
  pci_halt_sync_chk: assert property (@(posedge clk) disable iff (!por_n)
    pci_halt_req |-> !$past(stop_pad_in[1], 2));
endmodule

// File: tb/strap_cfg_latch_tb.sv
module strap_cfg_latch_tb_top;
  localparam int P = 8;
  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic [5:0] strap_pad_in = '0;
  logic [1:0] stop_pad_in = 2'b11;
  logic cfg_freq_sel = 1'b0;
  logic [2:0] cfg_freq_code = '0;
  logic [1:0] cfg_pair_en = '0;
  logic [5:0] strap_pad_oe;
  logic [1:0] pair_pad_oe, pair_clk_en;
  logic por_done, sdram_track_cpu, desktop_mode, cpu_buf_low_v;
  logic cpu_halt_req, pci_halt_req;
  logic [2:0] freq_code;
  int checks = 0, failures = 0;

  always #2.5 clk = ~clk;

  strap_cfg_latch #(.POR_CYCLES(P)) dut_i (.*);

  // stimulus: pins6 ovr1 rfs3 pairen2 | exp fs3 sdc1 desk1 lowv1 pairen2 pairoe2
  localparam int NV = 6;
  localparam logic [21:0] VEC [NV] = '{
    {6'b011101, 1'b0, 3'b010, 2'b11, 3'b101, 1'b1, 1'b1, 1'b0, 2'b11, 2'b11},
    {6'b100011, 1'b0, 3'b110, 2'b11, 3'b011, 1'b0, 1'b0, 1'b1, 2'b00, 2'b00},
    {6'b010000, 1'b1, 3'b111, 2'b01, 3'b111, 1'b0, 1'b1, 1'b0, 2'b01, 2'b11},
    {6'b111111, 1'b1, 3'b000, 2'b10, 3'b000, 1'b1, 1'b1, 1'b1, 2'b10, 2'b11},
    {6'b001110, 1'b1, 3'b100, 2'b11, 3'b100, 1'b1, 1'b0, 1'b0, 2'b00, 2'b00},
    {6'b101001, 1'b0, 3'b111, 2'b01, 3'b001, 1'b1, 1'b0, 1'b1, 2'b00, 2'b00}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic start_por(input logic [5:0] pins);
    por_n = 1'b0;
    strap_pad_in = pins;
    stop_pad_in = 2'b11;
    tick(2);
    por_n = 1'b1;
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    tick(2);
    check("R1 reset done", 8'(por_done), 8'd0);
    check("R1 reset oe", 8'({strap_pad_oe, pair_pad_oe}), 8'd0);
    check("R9 reset halt", 8'({cpu_halt_req, pci_halt_req}), 8'd0);

    for (int v = 0; v < NV; v++) begin
      logic [21:0] e;
      e = VEC[v];
      cfg_freq_sel = e[15];
      cfg_freq_code = e[14:12];
      cfg_pair_en = e[11:10];
      start_por(e[21:16]);
      tick(P);
      check("R1 done", 8'(por_done), 8'd1);
      check("R1 oe", 8'(strap_pad_oe), 8'h3f);
      check("R6 freq", 8'(freq_code), 8'(e[9:7]));
      check("R4 sdram src", 8'(sdram_track_cpu), 8'(e[6]));
      check("R5 mode", 8'(desktop_mode), 8'(e[5]));
      check("R7 buf volt", 8'(cpu_buf_low_v), 8'(e[4]));
      check("R8 pair en", 8'(pair_clk_en), 8'(e[3:2]));
      check("R5 pair oe", 8'(pair_pad_oe), 8'(e[1:0]));
      strap_pad_in = ~e[21:16];
      tick(4);
      check("R2 frozen freq", 8'(freq_code), 8'(e[9:7]));
      check("R2 frozen ctl", 8'({sdram_track_cpu, desktop_mode, cpu_buf_low_v}), 8'(e[6:4]));
    end

    cfg_freq_sel = 1'b0;
    cfg_pair_en = 2'b11;
    start_por(6'b000000);
    tick(P - 3);
    strap_pad_in[0] = 1'b1;
    tick(1);
    strap_pad_in[1] = 1'b1;
    tick(1);
    check("R1 done not early", 8'(por_done), 8'd0);
    tick(1);
    check("R1 done exact", 8'(por_done), 8'd1);
    check("R3 capture edge", 8'(freq_code), 8'd1);
    cfg_freq_code = 3'b110;
    cfg_freq_sel = 1'b1;
    #1;
    check("R6 live select", 8'(freq_code), 8'h6);
    cfg_freq_sel = 1'b0;
    #1;
    check("R6 back to strap", 8'(freq_code), 8'd1);
    check("R8 mobile gate", 8'(pair_clk_en), 8'd0);

    stop_pad_in = 2'b10;
    tick(1);
    check("R9 one edge", 8'(cpu_halt_req), 8'd0);
    tick(1);
    check("R9 two edges cpu", 8'(cpu_halt_req), 8'd1);
    check("R9 pci idle", 8'(pci_halt_req), 8'd0);
    stop_pad_in = 2'b01;
    tick(2);
    check("R9 pci halt", 8'({cpu_halt_req, pci_halt_req}), 8'b01);
    stop_pad_in = 2'b11;
    tick(2);
    check("R9 release", 8'({cpu_halt_req, pci_halt_req}), 8'd0);

    start_por(6'b010000);
    tick(P);
    stop_pad_in = 2'b00;
    tick(3);
    check("R5 desktop ignores stop", 8'({cpu_halt_req, pci_halt_req}), 8'd0);
    check("R8 desktop enable", 8'(pair_clk_en), 8'h3);
    por_n = 1'b0;
    #1;
    check("R1 async reset", 8'({por_done, pair_pad_oe}), 8'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule